// File: doc/BRIEF.md
# Word-Register Serial Bus Slave

This block is a slave-only endpoint for a two-wire, SMBus-style serial bus. It serves a small bank of 16-bit registers using word-sized write and read transfers. A fast system clock oversamples the bus clock and data lines. The block detects START, repeated START and STOP conditions, matches a fixed 7-bit device address, and takes a command byte that selects one register. It then moves a 16-bit word in or out. The low byte always goes first, and within each byte the most significant bit goes first.

Five command codes name control registers that the bus can only write. Their values reach the host logic as parallel outputs. Four command codes name status and identity words that the host logic supplies and the bus can only read. The block never starts a transfer. It controls SDA through a single active-low enable, so it can only pull the line low or release it.

Top module: `smb_word_slave`

## Requirements
- R1: The slave acknowledges (holds SDA low during the ninth clock) an address byte of {DEV_ADDR, 0} after START, which is 0x12 with the default address. Any other address byte gets no acknowledge, and the rest of that transfer has no effect on any register.
- R2: A write transfer (address 0x12, command, low byte, high byte, each acknowledged) sets the selected control word to {high, low}. ctrl_words index 0..4 holds the words for commands 0x12, 0x14, 0x15, 0x16 and 0x3F.
- R3: A read transfer (address 0x12, command, repeated START, address 0x13) returns the selected word low byte first, each byte MSB first. stat_words index 0..3 supplies the words for commands 0x11, 0x13, 0xFE and 0xFF.
- R4: A command byte outside the nine supported codes is not acknowledged, and the transfer changes no register.
- R5: A control word changes only after its high byte has been received and acknowledged. A transfer that stops after the low byte leaves the word unchanged.
- R6: Data bytes that a write sends to a read-only code (0x11, 0x13, 0xFE, 0xFF) are not acknowledged and change nothing. A read of a write-only code returns 0xFFFF, because SDA is left released.
- R7: If the master answers the low byte of a read with a NACK, the slave releases SDA for the rest of the transfer.
- R8: The slave changes its SDA drive only while SCL is low.
- R9: During reset, every control word holds its CTRL_RESET slice (index i at bits 16*i+15..16*i) and SDA is released.
- R10: The identity words at commands 0xFE and 0xFF read back like the other status words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| stat_words | input | 4x16 | Read-only words for commands 0x11, 0x13, 0xFE, 0xFF |
| ctrl_words | output | 5x16 | Write-only words for commands 0x12, 0x14, 0x15, 0x16, 0x3F |

## Verification
The bench builds the block with three synchronizer stages. This adds a cycle of latency between a bus edge and the slave's reaction, which tests the margin of the drive timing against SCL. It also gives CTRL_RESET a distinct nonzero pattern in every word, so that a write reaching the wrong word, or a stray write, shows up against the reset values. The default device address is kept, so mismatched addresses and the read-address form both come from the fixed 0x12/0x13 pair.

// File: rtl/smb_pkg.sv
package smb_pkg;
   localparam int WORD_W   = 16;
   localparam int BYTE_W   = 8;
   localparam int NUM_CTRL = 5;
   localparam int NUM_STAT = 4;

   // write-only control codes, index 0 first
   localparam logic [NUM_CTRL-1:0][BYTE_W-1:0] CTRL_CODES =
      {8'h3F, 8'h16, 8'h15, 8'h14, 8'h12};
   // read-only status / identity codes, index 0 first
   localparam logic [NUM_STAT-1:0][BYTE_W-1:0] STAT_CODES =
      {8'hFF, 8'hFE, 8'h13, 8'h11};

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR_W,
      ST_CMD,
      ST_WLO,
      ST_WHI,
      ST_ADDR_R,
      ST_TXLO,
      ST_TXHI,
      ST_SKIP
   } xfer_st_t;
endpackage

// File: rtl/smb_sync_edge.sv
module smb_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b1;
      else        chain_q[0] <= pin_i;
   end

   genvar g;
   generate
      for (g = 1; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= 1'b1;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic sda_lvl,
   output logic start_det,
   output logic stop_det
);
   logic sda_rise, sda_fall;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("smb_bus_cond: SYNC_STAGES must be at least 2");
      end
   endgenerate

   smb_sync_edge #(.STAGES(SYNC_STAGES)) u_scl (
      .clk(clk), .rst_n(rst_n), .pin_i(scl_i),
      .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
   );

   smb_sync_edge #(.STAGES(SYNC_STAGES)) u_sda (
      .clk(clk), .rst_n(rst_n), .pin_i(sda_i),
      .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
   );

   // data edges while the clock is high are framing conditions
   assign start_det = sda_fall & scl_lvl;
   assign stop_det  = sda_rise & scl_lvl;
endmodule

// File: rtl/smb_word_regs.sv
module smb_word_regs
   import smb_pkg::*;
#(
   parameter logic [NUM_CTRL*WORD_W-1:0] RESET_VAL = '0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [WORD_W-1:0]                  wr_data,
   input  logic [BYTE_W-1:0]                  sel_code,
   output logic                               sel_writable,
   output logic [WORD_W-1:0]                  sel_word,
   input  logic [BYTE_W-1:0]                  probe_code,
   output logic                               probe_known,
   input  logic [NUM_STAT-1:0][WORD_W-1:0]    stat_words,
   output logic [NUM_CTRL-1:0][WORD_W-1:0]    ctrl_words
);
   logic [NUM_CTRL-1:0] wr_hit;
   logic [NUM_STAT-1:0] rd_hit;
   logic [NUM_CTRL-1:0] probe_ctrl;
   logic [NUM_STAT-1:0] probe_stat;

   always_comb begin
      for (int i = 0; i < NUM_CTRL; i++) begin
         wr_hit[i]     = (sel_code == CTRL_CODES[i]);
         probe_ctrl[i] = (probe_code == CTRL_CODES[i]);
      end
      for (int j = 0; j < NUM_STAT; j++) begin
         rd_hit[j]     = (sel_code == STAT_CODES[j]);
         probe_stat[j] = (probe_code == STAT_CODES[j]);
      end
   end

   assign sel_writable = |wr_hit;
   assign probe_known  = (|probe_ctrl) | (|probe_stat);

   // unreadable codes give all ones: the line simply stays released
   always_comb begin
      sel_word = '1;
      for (int j = 0; j < NUM_STAT; j++) begin
         if (rd_hit[j]) sel_word = stat_words[j];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CTRL; i++)
            ctrl_words[i] <= RESET_VAL[i*WORD_W +: WORD_W];
      end else if (wr_en) begin
         for (int i = 0; i < NUM_CTRL; i++)
            if (wr_hit[i]) ctrl_words[i] <= wr_data;
      end
   end

   // commits only arrive for codes the bus may write
   assert_wr_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> sel_writable);

   genvar g;
   generate
      for (g = 0; g < NUM_CTRL; g++) begin : g_hold_chk
         assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(ctrl_words[g]) |-> $past(wr_en) && $past(wr_hit[g]));
      end
   endgenerate
endmodule

// File: rtl/smb_word_slave.sv
module smb_word_slave
   import smb_pkg::*;
#(
   parameter logic [6:0]                 DEV_ADDR    = 7'h09,
   parameter int                         SYNC_STAGES = 2,
   parameter logic [NUM_CTRL*WORD_W-1:0] CTRL_RESET  = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            scl_i,
   input  logic                            sda_i,
   output logic                            sda_oe,
   input  logic [NUM_STAT-1:0][WORD_W-1:0] stat_words,
   output logic [NUM_CTRL-1:0][WORD_W-1:0] ctrl_words
);
   localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
   localparam logic [BYTE_W-1:0] ADDR_RD = {DEV_ADDR, 1'b1};
   localparam int                CNT_W   = 4;

   generate
      if (DEV_ADDR == 7'h00) begin : g_bad_addr
         $error("smb_word_slave: address 0 is the general call");
      end
   endgenerate

   logic scl_lvl, scl_rise, scl_fall, sda_lvl, start_det, stop_det;

   smb_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det)
   );

   xfer_st_t          st_q;
   logic [CNT_W-1:0]  bcnt_q;
   logic [BYTE_W-1:0] rx_q;
   logic [BYTE_W-1:0] cmd_q;
   logic [BYTE_W-1:0] lo_q;
   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] wdata_q;
   logic              oe_q;
   logic              mack_q;
   logic              wr_en_q;

   logic              sel_writable, probe_known;
   logic [WORD_W-1:0] sel_word;
   logic [2:0]        bit_idx;

   smb_word_regs #(.RESET_VAL(CTRL_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en_q), .wr_data(wdata_q),
      .sel_code(cmd_q), .sel_writable(sel_writable), .sel_word(sel_word),
      .probe_code(rx_q), .probe_known(probe_known),
      .stat_words(stat_words), .ctrl_words(ctrl_words)
   );

   assign bit_idx = 3'd7 - bcnt_q[2:0];
   assign sda_oe  = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         bcnt_q  <= '0;
         rx_q    <= '0;
         cmd_q   <= '0;
         lo_q    <= '0;
         tx_q    <= '0;
         wdata_q <= '0;
         oe_q    <= 1'b0;
         mack_q  <= 1'b1;
         wr_en_q <= 1'b0;
      end else begin
         wr_en_q <= 1'b0;
         if (start_det) begin
            bcnt_q <= '0;
            // a restart right after the command byte opens the read phase
            if (st_q == ST_WLO && bcnt_q <= 4'd1) st_q <= ST_ADDR_R;
            else                                   st_q <= ST_ADDR_W;
         end else if (stop_det) begin
            bcnt_q <= '0;
            st_q   <= ST_IDLE;
         end else if (scl_rise) begin
            if (bcnt_q < 4'd8) rx_q <= {rx_q[BYTE_W-2:0], sda_lvl};
            if (bcnt_q == 4'd8) mack_q <= sda_lvl;
            if (bcnt_q < 4'd9) bcnt_q <= bcnt_q + 4'd1;
         end else if (scl_fall) begin
            if (bcnt_q == 4'd8) begin
               // byte complete: choose whether to acknowledge
               unique case (st_q)
                  ST_ADDR_W: begin
                     if (rx_q == ADDR_WR) oe_q <= 1'b1;
                     else begin oe_q <= 1'b0; st_q <= ST_SKIP; end
                  end
                  ST_CMD: begin
                     if (probe_known) begin oe_q <= 1'b1; cmd_q <= rx_q; end
                     else begin oe_q <= 1'b0; st_q <= ST_SKIP; end
                  end
                  ST_WLO: begin
                     if (sel_writable) begin oe_q <= 1'b1; lo_q <= rx_q; end
                     else begin oe_q <= 1'b0; st_q <= ST_SKIP; end
                  end
                  ST_WHI: begin
                     if (sel_writable) begin
                        oe_q    <= 1'b1;
                        wdata_q <= {rx_q, lo_q};
                     end else begin
                        oe_q <= 1'b0;
                        st_q <= ST_SKIP;
                     end
                  end
                  ST_ADDR_R: begin
                     if (rx_q == ADDR_RD) begin oe_q <= 1'b1; tx_q <= sel_word; end
                     else begin oe_q <= 1'b0; st_q <= ST_SKIP; end
                  end
                  default: oe_q <= 1'b0;
               endcase
            end else if (bcnt_q == 4'd9) begin
               // acknowledge slot over: move to the next byte
               bcnt_q <= '0;
               unique case (st_q)
                  ST_ADDR_W: begin oe_q <= 1'b0; st_q <= ST_CMD; end
                  ST_CMD:    begin oe_q <= 1'b0; st_q <= ST_WLO; end
                  ST_WLO:    begin oe_q <= 1'b0; st_q <= ST_WHI; end
                  ST_WHI: begin
                     oe_q    <= 1'b0;
                     wr_en_q <= 1'b1;
                     st_q    <= ST_SKIP;
                  end
                  ST_ADDR_R: begin
                     oe_q <= ~tx_q[7];
                     st_q <= ST_TXLO;
                  end
                  ST_TXLO: begin
                     if (!mack_q) begin
                        oe_q <= ~tx_q[15];
                        st_q <= ST_TXHI;
                     end else begin
                        oe_q <= 1'b0;
                        st_q <= ST_SKIP;
                     end
                  end
                  ST_TXHI: begin oe_q <= 1'b0; st_q <= ST_SKIP; end
                  default: oe_q <= 1'b0;
               endcase
            end else begin
               unique case (st_q)
                  ST_TXLO: oe_q <= ~tx_q[{1'b0, bit_idx}];
                  ST_TXHI: oe_q <= ~tx_q[{1'b1, bit_idx}];
                  default: oe_q <= 1'b0;
               endcase
            end
         end
      end
   end

   assert_addr_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) && st_q == ST_ADDR_W |-> rx_q == ADDR_WR);

   assert_cmd_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) && st_q == ST_CMD |-> probe_known);

   assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oe_q) |-> !scl_lvl);

   assert_skip_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_SKIP |-> !oe_q);
endmodule

// File: tb/smb_word_slave_tb.sv
module smb_word_slave_tb;
   import smb_pkg::*;

   localparam int T = 10;
   localparam logic [NUM_CTRL*WORD_W-1:0] RST_VAL =
      {16'h3F3F, 16'h1616, 16'h1515, 16'h1414, 16'h1212};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic [NUM_STAT-1:0][WORD_W-1:0] stat_w;
   logic [NUM_CTRL-1:0][WORD_W-1:0] ctrl_w;
   logic [NUM_CTRL-1:0][WORD_W-1:0] exp_ctrl;
   wire  sda_bus = sda_m & ~sda_oe;

   int n_chk = 0;
   int n_err = 0;
   int viol  = 0;
   int cyc   = 0;
   bit done  = 1'b0;
   logic oe_prev = 1'b0;

   always #2 clk = ~clk;

   smb_word_slave #(
      .DEV_ADDR(7'h09), .SYNC_STAGES(3), .CTRL_RESET(RST_VAL)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .stat_words(stat_w), .ctrl_words(ctrl_w)
   );

   // R8 monitor: drive must not move while the clock line is high
   always @(negedge clk) begin
      if (rst_n && scl_m && (sda_oe != oe_prev)) viol++;
      oe_prev <= sda_oe;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         n_err++;
         $display("FAIL watchdog: actual cycle %0d expected < 190000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int ctrl_idx(input logic [7:0] c);
      for (int i = 0; i < NUM_CTRL; i++) if (CTRL_CODES[i] == c) return i;
      return -1;
   endfunction

   function automatic int stat_idx(input logic [7:0] c);
      for (int j = 0; j < NUM_STAT; j++) if (STAT_CODES[j] == c) return j;
      return -1;
   endfunction

   function automatic logic [15:0] exp_read(input logic [7:0] c);
      int j = stat_idx(c);
      if (j < 0) return 16'hFFFF;
      return stat_w[j];
   endfunction

   task automatic bus_start();
      sda_m = 1'b1; wt(T);
      scl_m = 1'b1; wt(T);
      sda_m = 1'b0; wt(T);
      scl_m = 1'b0; wt(T);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wt(T);
      scl_m = 1'b1; wt(T);
      sda_m = 1'b1; wt(T);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wt(T);
         scl_m = 1'b1; wt(T);
         scl_m = 1'b0; wt(2);
      end
      sda_m = 1'b1; wt(T);
      scl_m = 1'b1; wt(T/2);
      acked = ~sda_bus;
      wt(T/2);
      scl_m = 1'b0; wt(2);
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wt(T);
         scl_m = 1'b1; wt(T/2);
         b[i] = sda_bus;
         wt(T/2);
         scl_m = 1'b0; wt(2);
      end
      sda_m = nack; wt(T);
      scl_m = 1'b1; wt(T);
      scl_m = 1'b0; wt(2);
      sda_m = 1'b1;
   endtask

   task automatic do_write(input logic [6:0] a, input logic [7:0] c,
                           input logic [15:0] d, output logic [3:0] acks);
      bus_start();
      send_byte({a, 1'b0}, acks[0]);
      send_byte(c, acks[1]);
      send_byte(d[7:0], acks[2]);
      send_byte(d[15:8], acks[3]);
      bus_stop();
   endtask

   task automatic do_partial(input logic [7:0] c, input logic [7:0] lo);
      logic a0, a1, a2;
      bus_start();
      send_byte(8'h12, a0);
      send_byte(c, a1);
      send_byte(lo, a2);
      bus_stop();
   endtask

   task automatic do_read(input logic [7:0] c, output logic [15:0] v,
                          output logic [2:0] acks);
      bus_start();
      send_byte(8'h12, acks[0]);
      send_byte(c, acks[1]);
      bus_start();
      send_byte(8'h13, acks[2]);
      recv_byte(1'b0, v[7:0]);
      recv_byte(1'b1, v[15:8]);
      bus_stop();
   endtask

   task automatic model_write(input logic [7:0] c, input logic [15:0] d);
      int i = ctrl_idx(c);
      if (i >= 0) exp_ctrl[i] = d;
   endtask

   initial begin
      logic [3:0]  wa;
      logic [2:0]  ra;
      logic [15:0] rv;
      logic [7:0]  b0, b1;
      logic        ak;
      logic [7:0]  pool [10];
      void'($urandom(32'h5EED_0042));
      pool = '{8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16, 8'h3F, 8'hFE, 8'hFF, 8'h00};
      stat_w = {16'hD1E5, 16'h4D57, 16'h0A3C, 16'hC35A};
      exp_ctrl = RST_VAL;
      wt(10);
      check("R9 reset words", ctrl_w, RST_VAL);
      check("R9 reset sda released", sda_oe, 1'b0);
      rst_n = 1'b1;
      wt(10);

      do_write(7'h09, 8'h14, 16'h1234, wa);
      model_write(8'h14, 16'h1234);
      check("R1 acks on matching address", wa, 4'b1111);
      check("R2 write 0x14", ctrl_w, exp_ctrl);

      do_write(7'h09, 8'h3F, 16'hA55A, wa);
      model_write(8'h3F, 16'hA55A);
      check("R2 write 0x3F", ctrl_w, exp_ctrl);

      do_write(7'h19, 8'h15, 16'hBEEF, wa);
      check("R1 foreign address not acked", wa, 4'b0000);
      check("R1 foreign address no effect", ctrl_w, exp_ctrl);

      do_write(7'h09, 8'h20, 16'h0102, wa);
      check("R4 unknown command nacked", wa, 4'b0001);
      check("R4 unknown command no effect", ctrl_w, exp_ctrl);

      do_partial(8'h16, 8'h77);
      check("R5 partial write keeps word", ctrl_w, exp_ctrl);

      do_read(8'h11, rv, ra);
      check("R3 read acks", ra, 3'b111);
      check("R3 read 0x11", rv, stat_w[0]);
      do_read(8'h13, rv, ra);
      check("R3 read 0x13", rv, stat_w[1]);
      do_read(8'hFE, rv, ra);
      check("R10 read 0xFE", rv, stat_w[2]);
      do_read(8'hFF, rv, ra);
      check("R10 read 0xFF", rv, stat_w[3]);

      do_write(7'h09, 8'h13, 16'h9999, wa);
      check("R6 write to read-only nacked", wa, 4'b0011);
      check("R6 write to read-only no effect", ctrl_w, exp_ctrl);
      do_read(8'h14, rv, ra);
      check("R6 read of write-only", {ra, rv}, {3'b111, 16'hFFFF});

      // R7: NACK the low byte, keep clocking, the line must stay released
      bus_start();
      send_byte(8'h12, ak);
      send_byte(8'h11, ak);
      bus_start();
      send_byte(8'h13, ak);
      recv_byte(1'b1, b0);
      recv_byte(1'b1, b1);
      bus_stop();
      check("R7 low byte before nack", b0, stat_w[0][7:0]);
      check("R7 released after nack", b1, 8'hFF);

      for (int k = 0; k < 40; k++) begin
         logic [7:0]  c;
         logic [15:0] d;
         logic        kn, wr;
         int          kind;
         c = pool[$urandom % 10];
         if (c == 8'h00) c = 8'($urandom);
         d = 16'($urandom);
         kind = int'($urandom % 3);
         kn = (ctrl_idx(c) >= 0) || (stat_idx(c) >= 0);
         wr = (ctrl_idx(c) >= 0);
         if (k % 8 == 0) stat_w[$urandom % 4] = 16'($urandom);
         if (kind == 0) begin
            do_write(7'h09, c, d, wa);
            if (wr) model_write(c, d);
            check("R2 random write acks", wa, {wr, wr, kn, 1'b1});
         end else if (kind == 1) begin
            do_read(c, rv, ra);
            check("R3 random read", {ra, rv},
                  {kn, kn, 1'b1, (kn ? exp_read(c) : 16'hFFFF)});
         end else begin
            do_partial(c, d[7:0]);
         end
         check("R5 random bank contents", ctrl_w, exp_ctrl);
      end

      check("R8 drive changes with clock high", viol, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule